// File: doc/BRIEF.md
# TLB Miss Context Register Unit

This unit sits on the exception path of a paged memory management unit. Software loads the base of a linear page-entry table into the upper field of a 32-bit context word. When the translation lookaside buffer reports a miss, the unit puts the faulting virtual page number into the middle of that word. The word then holds the aligned address of the one 4-byte table slot that maps the failing page. In the same cycle the unit captures the whole faulting address in a read-only bad-address register.

The unit also picks the handler for the miss. A miss on a user address (bit 31 clear) goes to the short refill entry at the exception base. Any other miss, including one in the mapped kernel window (top bits 110), goes to the general entry at base + 0x080. The table covers the 2 GB user space in 2 MB: 2^19 pages of 4 bytes each. A refill handler reads the context word and loads from that address directly.

Top module: `tlb_ctx_unit`

## Requirements
- R1: When rst_ni is low, the context word, the bad-address register and vec_valid_o are all zero.
- R2: A write (wr_en_i) loads wr_data_i[31:21] into context bits 31:21. Context bits 20:0 are unchanged by the write.
- R3: A miss (miss_i) loads miss_va_i[30:12] into context bits 20:2, visible one cycle later. A miss alone leaves bits 31:21 unchanged.
- R4: Context bits 1:0 always read as zero.
- R5: A miss captures all 32 bits of miss_va_i into the bad-address register at the same edge as R3. Writes never change this register, and it holds its value when there is no miss.
- R6: After a miss with miss_va_i[31]=0, vec_valid_o is 1 for one cycle, with vec_gen_o=0 and vec_addr_o = exc_base_i.
- R7: After a miss with miss_va_i[31]=1 (this covers the 110 kernel window), vec_valid_o is 1, with vec_gen_o=1 and vec_addr_o = exc_base_i + 0x080.
- R8: When a write and a miss occur in the same cycle, bits 31:21 take the written value and bits 20:2 take the miss page number.
- R9: With rd_sel_i=0, rd_data_o returns the context word. With rd_sel_i=1, rd_data_o returns the bad-address register. The read path is combinational.
- R10: vec_valid_o is 1 exactly in the cycle after each miss strobe, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the context base field |
| wr_data_i | input | 32 | Write data; only bits 31:21 are used |
| rd_sel_i | input | 1 | Read select: 0 selects context, 1 selects bad address |
| rd_data_o | output | 32 | Read data |
| miss_i | input | 1 | TLB miss strobe |
| miss_va_i | input | 32 | Faulting virtual address |
| exc_base_i | input | 32 | Exception vector base |
| ctx_o | output | 32 | Context word |
| badva_o | output | 32 | Captured faulting address |
| vec_valid_o | output | 1 | Vector valid, one cycle after a miss |
| vec_gen_o | output | 1 | 1 selects the general vector, 0 the user refill vector |
| vec_addr_o | output | 32 | Handler address |

## Verification
A software write to the base field and a miss strobe can land on the same clock edge, and both target the context word. The stimulus table holds several vectors that raise wr_en_i and miss_i together, with distinct base and page patterns. The context word that results must carry the written base bits above the missed page number. The bad-address register and the vector select must behave exactly as they do for a miss alone.

// File: rtl/tlb_ctx_pkg.sv
package tlb_ctx_pkg;
  typedef enum logic {
    VEC_REFILL  = 1'b0,
    VEC_GENERAL = 1'b1
  } vec_kind_e;
endpackage

// File: rtl/tlb_ctx_reg.sv
module tlb_ctx_reg #(
  parameter int AW = 32,
  parameter int PG = 12,
  localparam int VPN_W  = AW - 1 - PG,
  localparam int BASE_W = AW - 2 - VPN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic              miss_i,
  input  logic [AW-1:0]     miss_va_i,
  output logic [AW-1:0]     ctx_o,
  output logic [AW-1:0]     badva_o
);
  logic [BASE_W-1:0] base_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [AW-1:0]     badva_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      vpn_q   <= '0;
      badva_q <= '0;
    end else begin
      if (wr_en_i) base_q <= wr_base_i;
      if (miss_i) begin
        // user page number: drop the region bit and the page offset
        vpn_q   <= miss_va_i[AW-2:PG];
        badva_q <= miss_va_i;
      end
    end
  end

  assign ctx_o   = {base_q, vpn_q, 2'b00};
  assign badva_o = badva_q;

  a_r2_wr_keeps_vpn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !miss_i) |=> (ctx_o[AW-BASE_W-1:0] == $past(ctx_o[AW-BASE_W-1:0])));
  a_r3_miss_vpn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> (ctx_o[AW-BASE_W-1:2] == $past(miss_va_i[AW-2:PG])));
  a_r3_miss_keeps_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !wr_en_i) |=> $stable(ctx_o[AW-1:AW-BASE_W]));
  a_r5_badva_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> $stable(badva_o));
  a_r5_badva_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> (badva_o == $past(miss_va_i)));
endmodule

// File: rtl/tlb_vec_sel.sv
module tlb_vec_sel
  import tlb_ctx_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [11:0] REFILL_OFF = 12'h000,
  parameter logic [11:0] GEN_OFF    = 12'h080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          miss_i,
  input  logic          user_i,
  input  logic [AW-1:0] exc_base_i,
  output logic          vec_valid_o,
  output vec_kind_e     vec_kind_o,
  output logic [AW-1:0] vec_addr_o
);
  vec_kind_e     kind_d;
  logic [AW-1:0] addr_d;

  always_comb begin
    kind_d = user_i ? VEC_REFILL : VEC_GENERAL;
    addr_d = exc_base_i + AW'(user_i ? REFILL_OFF : GEN_OFF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_kind_o  <= VEC_REFILL;
      vec_addr_o  <= '0;
    end else begin
      vec_valid_o <= miss_i;
      if (miss_i) begin
        vec_kind_o <= kind_d;
        vec_addr_o <= addr_d;
      end
    end
  end

  a_r10_vec_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> vec_valid_o);
  a_r10_vec_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> !vec_valid_o);
endmodule

// File: rtl/tlb_ctx_unit.sv
module tlb_ctx_unit
  import tlb_ctx_pkg::*;
#(
  parameter int AW = 32,
  parameter int PG = 12,
  localparam int VPN_W  = AW - 1 - PG,
  localparam int BASE_W = AW - 2 - VPN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          rd_sel_i,
  output logic [AW-1:0] rd_data_o,
  input  logic          miss_i,
  input  logic [AW-1:0] miss_va_i,
  input  logic [AW-1:0] exc_base_i,
  output logic [AW-1:0] ctx_o,
  output logic [AW-1:0] badva_o,
  output logic          vec_valid_o,
  output logic          vec_gen_o,
  output logic [AW-1:0] vec_addr_o
);
  vec_kind_e kind;

  tlb_ctx_reg #(.AW(AW), .PG(PG)) u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_base_i (wr_data_i[AW-1 -: BASE_W]),
    .miss_i    (miss_i),
    .miss_va_i (miss_va_i),
    .ctx_o     (ctx_o),
    .badva_o   (badva_o)
  );

  tlb_vec_sel #(.AW(AW)) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (miss_i),
    .user_i      (!miss_va_i[AW-1]),
    .exc_base_i  (exc_base_i),
    .vec_valid_o (vec_valid_o),
    .vec_kind_o  (kind),
    .vec_addr_o  (vec_addr_o)
  );

  assign vec_gen_o = (kind == VEC_GENERAL);
  assign rd_data_o = rd_sel_i ? badva_o : ctx_o;

  a_r4_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i |-> (rd_data_o[1:0] == 2'b00));
  a_r8_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && miss_i) |=> (ctx_o[AW-1:AW-BASE_W] == $past(wr_data_i[AW-1:AW-BASE_W])));
  a_r6_user_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !miss_va_i[AW-1]) |=> !vec_gen_o);
  a_r7_gen_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && miss_va_i[AW-1]) |=> vec_gen_o);
endmodule

// File: tb/tlb_ctx_unit_test.sv
`timescale 1ns/1ps
module tlb_ctx_unit_test;
  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        miss;
    logic [31:0] va;
    logic        gen;  // expected vector kind when miss
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,          1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h1234_5678, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'hC000_3000, 1'b1},
    '{1'b1, 32'h0020_0000, 1'b1, 32'h7FFF_F000, 1'b0},
    '{1'b0, 32'h0,         1'b0, 32'h0,          1'b0},
    '{1'b1, 32'hABCD_EFFF, 1'b0, 32'h5555_5555, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'hE123_4000, 1'b1},
    '{1'b0, 32'h0,         1'b1, 32'h0000_0FFF, 1'b0},
    '{1'b1, 32'h5A5A_0000, 1'b1, 32'hDFFF_FFFF, 1'b1},
    '{1'b0, 32'h0,         1'b0, 32'hFFFF_FFFF, 1'b0}
  };

  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, miss = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0, miss_va = '0;
  logic [31:0] rd_data, ctx, badva, vaddr;
  logic        vvalid, vgen;

  int checks = 0, errors = 0;
  logic [10:0] m_base = '0;
  logic [18:0] m_vpn = '0;
  logic [31:0] m_bad = '0;

  always #2 clk = ~clk;

  tlb_ctx_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .miss_i(miss), .miss_va_i(miss_va),
    .exc_base_i(BASE), .ctx_o(ctx), .badva_o(badva), .vec_valid_o(vvalid),
    .vec_gen_o(vgen), .vec_addr_o(vaddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reads();
    logic [31:0] ec;
    ec = {m_base, m_vpn, 2'b00};
    rd_sel = 1'b0; #0.2;
    chk("R9 rd ctx", rd_data, ec);
    chk("R4 low bits", {30'b0, rd_data[1:0]}, 32'h0);
    rd_sel = 1'b1; #0.2;
    chk("R9 rd badva", rd_data, m_bad);
    rd_sel = 1'b0;
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    wr_en = v.wr; wr_data = v.wd; miss = v.miss; miss_va = v.va;
    @(posedge clk); #1;
    wr_en = 1'b0; miss = 1'b0;
    if (v.wr) m_base = v.wd[31:21];
    if (v.miss) begin m_vpn = v.va[30:12]; m_bad = v.va; end
    chk(v.wr && v.miss ? "R8 ctx" : (v.miss ? "R3 ctx" : "R2 ctx"), ctx, {m_base, m_vpn, 2'b00});
    chk("R5 badva", badva, m_bad);
    chk("R10 vvalid", {31'b0, vvalid}, {31'b0, v.miss});
    if (v.miss) begin
      chk(v.gen ? "R7 kind" : "R6 kind", {31'b0, vgen}, {31'b0, v.gen});
      chk(v.gen ? "R7 addr" : "R6 addr", vaddr, v.gen ? BASE + 32'h80 : BASE);
    end
    check_reads();
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk("R1 ctx", ctx, 32'h0);
    chk("R1 badva", badva, 32'h0);
    chk("R1 vvalid", {31'b0, vvalid}, 32'h0);
    #10 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) step(VECS[i]);
    // idle: one-cycle pulse already checked; idle step keeps state
    step('{1'b0, 32'h0, 1'b0, 32'h0, 1'b0});
    // back-to-back misses: pulse stays high, each captures its own page
    step('{1'b0, 32'h0, 1'b1, 32'h0ABC_D000, 1'b0});
    step('{1'b0, 32'h0, 1'b1, 32'hC7FF_F000, 1'b1});
    step('{1'b1, 32'h001F_FFFF, 1'b0, 32'h0, 1'b0});  // R2: low-field-only write ignored in base
    // asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #0.5;
    chk("R1 ctx async", ctx, 32'h0);
    chk("R1 badva async", badva, 32'h0);
    chk("R1 vvalid async", {31'b0, vvalid}, 32'h0);
    m_base = '0; m_vpn = '0; m_bad = '0;
    #5 rst_n = 1'b1;
    step('{1'b1, 32'hFFE0_0000, 1'b1, 32'h8000_1000, 1'b1});
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule